// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented logical address into a physical address. A request carries a 16-bit selector and an offset. The selector names a segment by number, picks one of two register-held tables (global or local), and carries the privilege of the requester. The chosen table entry supplies a base, a limit, a required privilege level and a present bit.

The block checks the request against that entry. A legal request returns base plus offset. An illegal one returns a fault code and a zeroed address. The result is registered and appears one clock after the request. Software fills the tables through a configuration port. The same port also sets how many entries of each table are in use.

Top module: `seg_xlate`

## Requirements
- R1: Selector fields are: bits [15:3] the segment number, bit 2 the table select (0 = global, 1 = local), and bits [1:0] the requested privilege. The whole 13-bit segment number is compared against the populated count, and its low 3 bits index the entry.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A legal request returns `rsp_fault` = 0 and `rsp_paddr` = base + offset. The offset is zero-extended, and the sum wraps modulo 2^24.
- R4: An offset greater than or equal to the entry's limit gives fault code 1 (limit). A limit of 0 therefore faults every offset.
- R5: A segment number greater than or equal to the selected table's populated count gives fault code 2 (index).
- R6: An entry whose present bit is clear gives fault code 3 (not present).
- R7: A requested privilege numerically greater than the entry's level gives fault code 4 (privilege). An equal or lower value is allowed.
- R8: When several faults apply, the reported code follows this priority: index, then not present, then privilege, then limit.
- R9: Whenever `rsp_fault` is nonzero, `rsp_paddr` is 0.
- R10: The global and local tables are separate. A write to an entry of one table leaves the same index of the other table unchanged.
- R11: After reset, every entry is not present, both counts are 0 and `rsp_valid` is low. Any request therefore returns fault code 2.
- R12: `cfg_we` writes the entry `cfg_idx` of table `cfg_tbl`. `cfg_cnt_we` sets that table's populated count, and a value above 8 is held at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Selector: segment number, table select, requested privilege |
| req_ofs | input | 16 | Offset within the segment |
| cfg_we | input | 1 | Write one table entry |
| cfg_cnt_we | input | 1 | Write the populated count of a table |
| cfg_tbl | input | 1 | Table addressed by the configuration port (0 global, 1 local) |
| cfg_idx | input | 3 | Entry index for `cfg_we` |
| cfg_base | input | 24 | Entry base |
| cfg_limit | input | 16 | Entry limit (segment length) |
| cfg_dpl | input | 2 | Entry privilege level |
| cfg_present | input | 1 | Entry present bit |
| cfg_cnt | input | 4 | Populated count value |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_fault | output | 3 | Fault code (0 ok, 1 limit, 2 index, 3 not present, 4 privilege) |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |

## Verification
The hardest case to reach from the ports is the fault priority, because several illegal conditions must hold at once. The bench programs entries whose stored fields are deliberately bad. It writes a fully valid entry just past a table's populated count. It also writes an absent entry with a low privilege level and a short limit, and a present entry that breaks both the privilege and the limit checks. Each is then requested with a privilege and offset that break every lower-priority check, and the bench confirms that only the highest-priority code is reported. Count clamping is reached by writing an oversized count, then probing segment numbers 7 and 8.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int SEL_W   = 16;
   localparam int RPL_W   = 2;
   localparam int TI_BIT  = 2;
   localparam int SEGN_LO = 3;
   localparam int SEGN_W  = SEL_W - SEGN_LO;
   localparam int N_TBL   = 2;

   typedef enum logic [2:0] {
      F_OK     = 3'd0,
      F_LIMIT  = 3'd1,
      F_INDEX  = 3'd2,
      F_ABSENT = 3'd3,
      F_PRIV   = 3'd4
   } fault_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3,
   parameter int PA_W  = 24,
   parameter int OFS_W = 16,
   parameter int PL_W  = 2,
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PA_W-1:0]  wr_base,
   input  logic [OFS_W-1:0] wr_limit,
   input  logic [PL_W-1:0]  wr_dpl,
   input  logic             wr_present,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PA_W-1:0]  rd_base,
   output logic [OFS_W-1:0] rd_limit,
   output logic [PL_W-1:0]  rd_dpl,
   output logic             rd_present,
   output logic [CNT_W-1:0] rd_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [PA_W-1:0]  base_q  [DEPTH];
   logic [OFS_W-1:0] limit_q [DEPTH];
   logic [PL_W-1:0]  dpl_q   [DEPTH];
   logic [DEPTH-1:0] pres_q;
   logic [CNT_W-1:0] cnt_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            limit_q[e] <= '0;
            dpl_q[e]   <= '0;
            pres_q[e]  <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
            dpl_q[e]   <= wr_dpl;
            pres_q[e]  <= wr_present;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_we) cnt_q <= (cnt_in > CNT_MAX) ? CNT_MAX : cnt_in;
   end

   assign rd_base    = base_q[rd_idx];
   assign rd_limit   = limit_q[rd_idx];
   assign rd_dpl     = dpl_q[rd_idx];
   assign rd_present = pres_q[rd_idx];
   assign rd_cnt     = cnt_q;

   // R12: the count never exceeds the table depth
   p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
   // R12: a written present bit is stored at the written index
   p_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pres_q[$past(wr_idx)] == $past(wr_present));
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int PA_W  = 24,
   parameter int OFS_W = 16,
   parameter int PL_W  = 2,
   localparam int CNT_W = IDX_W + 1
) (
   input  logic [SEGN_W-1:0] seg_num,
   input  logic [PL_W-1:0]   rpl,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [PA_W-1:0]   base,
   input  logic [OFS_W-1:0]  limit,
   input  logic [PL_W-1:0]   dpl,
   input  logic              present,
   output fault_e            fault,
   output logic [PA_W-1:0]   paddr
);
   logic idx_bad, lim_bad, priv_bad;

   assign idx_bad  = seg_num >= {{(SEGN_W-CNT_W){1'b0}}, cnt};
   assign lim_bad  = ofs >= limit;
   assign priv_bad = rpl > dpl;

   always_comb begin
      if (idx_bad)       fault = F_INDEX;
      else if (!present) fault = F_ABSENT;
      else if (priv_bad) fault = F_PRIV;
      else if (lim_bad)  fault = F_LIMIT;
      else               fault = F_OK;
   end

   assign paddr = (fault == F_OK) ? base + PA_W'(ofs) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int PA_W  = 24,
   parameter int OFS_W = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [OFS_W-1:0] req_ofs,
   input  logic             cfg_we,
   input  logic             cfg_cnt_we,
   input  logic             cfg_tbl,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [OFS_W-1:0] cfg_limit,
   input  logic [RPL_W-1:0] cfg_dpl,
   input  logic             cfg_present,
   input  logic [CNT_W-1:0] cfg_cnt,
   output logic             rsp_valid,
   output logic [2:0]       rsp_fault,
   output logic [PA_W-1:0]  rsp_paddr
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (PA_W < OFS_W) begin : g_bad_pa
      $error("PA_W must be at least OFS_W");
   end
   if (CNT_W > SEGN_W) begin : g_bad_cnt
      $error("table too deep for the selector");
   end

   logic [SEGN_W-1:0] seg_num;
   logic              tsel;
   logic [RPL_W-1:0]  rpl;
   assign seg_num = req_sel[SEL_W-1:SEGN_LO];
   assign tsel    = req_sel[TI_BIT];
   assign rpl     = req_sel[RPL_W-1:0];

   logic [PA_W-1:0]  t_base  [N_TBL];
   logic [OFS_W-1:0] t_limit [N_TBL];
   logic [RPL_W-1:0] t_dpl   [N_TBL];
   logic             t_pres  [N_TBL];
   logic [CNT_W-1:0] t_cnt   [N_TBL];

   for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
      seg_table #(
         .DEPTH(DEPTH), .IDX_W(IDX_W), .PA_W(PA_W), .OFS_W(OFS_W), .PL_W(RPL_W)
      ) u_tbl (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && cfg_tbl == 1'(t)),
         .wr_idx    (cfg_idx),
         .wr_base   (cfg_base),
         .wr_limit  (cfg_limit),
         .wr_dpl    (cfg_dpl),
         .wr_present(cfg_present),
         .cnt_we    (cfg_cnt_we && cfg_tbl == 1'(t)),
         .cnt_in    (cfg_cnt),
         .rd_idx    (seg_num[IDX_W-1:0]),
         .rd_base   (t_base[t]),
         .rd_limit  (t_limit[t]),
         .rd_dpl    (t_dpl[t]),
         .rd_present(t_pres[t]),
         .rd_cnt    (t_cnt[t])
      );
   end

   fault_e           chk_fault;
   logic [PA_W-1:0]  chk_paddr;

   seg_check #(
      .IDX_W(IDX_W), .PA_W(PA_W), .OFS_W(OFS_W), .PL_W(RPL_W)
   ) u_chk (
      .seg_num(seg_num),
      .rpl    (rpl),
      .ofs    (req_ofs),
      .cnt    (t_cnt[tsel]),
      .base   (t_base[tsel]),
      .limit  (t_limit[tsel]),
      .dpl    (t_dpl[tsel]),
      .present(t_pres[tsel]),
      .fault  (chk_fault),
      .paddr  (chk_paddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= F_OK;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= chk_fault;
            rsp_paddr <= chk_paddr;
         end
      end
   end

   // R2: one result per request, one cycle later
   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R9: a faulting result never carries an address
   p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != F_OK) |-> rsp_paddr == '0);
   // R5: a segment number beyond the populated count reports the index fault
   p_index_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seg_num >= {{(SEGN_W-CNT_W){1'b0}}, t_cnt[tsel]})
      |=> rsp_fault == F_INDEX);
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic [15:0] req_ofs = '0;
   logic        cfg_we = 1'b0, cfg_cnt_we = 1'b0, cfg_tbl = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [23:0] cfg_base = '0;
   logic [15:0] cfg_limit = '0;
   logic [1:0]  cfg_dpl = '0;
   logic        cfg_present = 1'b0;
   logic [3:0]  cfg_cnt = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_fault;
   logic [23:0] rsp_paddr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_xlate uut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mksel(logic [12:0] seg, logic ti, logic [1:0] rpl);
      return {seg, ti, rpl};
   endfunction

   task automatic put_entry(logic tbl, logic [2:0] idx, logic [23:0] base,
                            logic [15:0] lim, logic [1:0] dpl, logic pres);
      @(negedge clk);
      cfg_we = 1'b1; cfg_tbl = tbl; cfg_idx = idx; cfg_base = base;
      cfg_limit = lim; cfg_dpl = dpl; cfg_present = pres;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_cnt(logic tbl, logic [3:0] cnt);
      @(negedge clk);
      cfg_cnt_we = 1'b1; cfg_tbl = tbl; cfg_cnt = cnt;
      @(negedge clk);
      cfg_cnt_we = 1'b0;
   endtask

   // drives one request and checks the result one clock later
   task automatic xlate(string req, logic [15:0] sel, logic [15:0] ofs,
                        logic [2:0] exp_f, logic [23:0] exp_a);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_ofs = ofs;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, 32'(rsp_valid), 32'd1);
      check({req, " fault"}, 32'(rsp_fault), 32'(exp_f));
      check({req, " paddr"}, 32'(rsp_paddr), 32'(exp_a));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R11 valid low after reset", 32'(rsp_valid), 32'd0);
      xlate("R11 empty table", mksel(13'd0, 1'b0, 2'd0), 16'd0, 3'd2, 24'd0);
      @(negedge clk);
      check("R2 valid drops", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_legal;
      put_cnt(1'b0, 4'd4);
      put_entry(1'b0, 3'd1, 24'h100000, 16'h0100, 2'd3, 1'b1);
      xlate("R3 legal top", mksel(13'd1, 1'b0, 2'd0), 16'h00FF, 3'd0, 24'h1000FF);
      xlate("R3 legal zero", mksel(13'd1, 1'b0, 2'd3), 16'h0000, 3'd0, 24'h100000);
      xlate("R4 at limit", mksel(13'd1, 1'b0, 2'd0), 16'h0100, 3'd1, 24'd0);
      put_entry(1'b0, 3'd0, 24'hFFFF00, 16'hFFFF, 2'd3, 1'b1);
      xlate("R3 wrap", mksel(13'd0, 1'b0, 2'd0), 16'h0200, 3'd0, 24'h000100);
      put_entry(1'b0, 3'd3, 24'h300000, 16'h0000, 2'd3, 1'b1);
      xlate("R4 zero limit", mksel(13'd3, 1'b0, 2'd0), 16'h0000, 3'd1, 24'd0);
   endtask

   task automatic t_index;
      xlate("R1 high seg bits", mksel(13'h1001, 1'b0, 2'd0), 16'h0001, 3'd2, 24'd0);
      xlate("R5 past count", mksel(13'd4, 1'b0, 2'd0), 16'h0001, 3'd2, 24'd0);
   endtask

   task automatic t_local;
      put_cnt(1'b1, 4'd2);
      put_entry(1'b1, 3'd1, 24'h200000, 16'h0010, 2'd1, 1'b1);
      xlate("R10 local read", mksel(13'd1, 1'b1, 2'd1), 16'h0005, 3'd0, 24'h200005);
      xlate("R10 global untouched", mksel(13'd1, 1'b0, 2'd0), 16'h0005, 3'd0, 24'h100005);
      xlate("R7 priv too low", mksel(13'd1, 1'b1, 2'd2), 16'h0005, 3'd4, 24'd0);
      xlate("R5 local count", mksel(13'd2, 1'b1, 2'd0), 16'h0000, 3'd2, 24'd0);
   endtask

   task automatic t_priority;
      put_entry(1'b0, 3'd2, 24'h400000, 16'h0004, 2'd0, 1'b0);
      xlate("R6 absent", mksel(13'd2, 1'b0, 2'd0), 16'h0001, 3'd3, 24'd0);
      xlate("R8 absent over priv+limit", mksel(13'd2, 1'b0, 2'd3), 16'h0009, 3'd3, 24'd0);
      put_entry(1'b0, 3'd3, 24'h300000, 16'h0004, 2'd0, 1'b1);
      xlate("R8 priv over limit", mksel(13'd3, 1'b0, 2'd3), 16'h0009, 3'd4, 24'd0);
      put_entry(1'b0, 3'd4, 24'h500000, 16'h0100, 2'd3, 1'b1);
      xlate("R8 index over valid entry", mksel(13'd4, 1'b0, 2'd0), 16'h0001, 3'd2, 24'd0);
   endtask

   task automatic t_clamp;
      put_cnt(1'b0, 4'd15);
      put_entry(1'b0, 3'd7, 24'h700000, 16'h0100, 2'd3, 1'b1);
      xlate("R12 clamped idx7", mksel(13'd7, 1'b0, 2'd0), 16'h0002, 3'd0, 24'h700002);
      xlate("R12 clamped seg8", mksel(13'd8, 1'b0, 2'd0), 16'h0002, 3'd2, 24'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_legal();
      t_index();
      t_local();
      t_priority();
      t_clamp();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule